// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block is a 16-bit up-counting timer with two compare registers that together shape a pulse-width modulated output. One of several count enable inputs is chosen as the count clock. On each enabled cycle the counter advances. Compare B marks the last position of the period, and the counter returns to zero after it. Compare A marks the position where the output turns on. The output turns off again at the compare B position. An inversion bit chooses which pin level counts as "off".

A fine mode doubles the resolution of the on edge. In this mode the position is the counter with one extra half-step bit appended below it, so compare A can take values from 0 to 2*B+1. When compare A lies beyond the last position of the current mode, no A match occurs and the output stays at the off level.

Each compare match sets a sticky cause flag. Software clears a flag by writing 1 to it. Per-source enables gate the flags onto two interrupt lines. Software reaches every setting through a simple register write port and a combinational read port.

Top module: `pwm_timer2c`

Register map (3-bit address, data width = counter width):
- 0 control: bit0 run, bit1 fine mode, bit2 invert, bits[5:4] count-enable select
- 1 compare A
- 2 compare B
- 3 cause flags: bit0 A, bit1 B (write 1 to clear, read back)
- 4 interrupt enables: bit0 A, bit1 B
- 5 counter value (read only; in fine mode the half-step bit is dropped)

## Requirements
- R1: While run (control bit0) is 1, writes to the fine bit (bit1) and the select field (bits[5:4]) are ignored. The run and invert bits still take the written value.
- R2: While run is 0, the counter reads 0 and the output stays at the off level. After run is set, counting starts from position 0.
- R3: In normal mode each tick (selected enable high while running) advances the position by one. Position B is followed by 0, so the period is B+1 ticks. The output turns on after the tick at position A and turns off after the tick at position B. With A=0 and B=1 the output period is 2 ticks.
- R4: In normal mode with A > B there is no A match and no A flag, and the output stays off.
- R5: In fine mode the position runs from 0 to 2*B+1, and the counter register reads position/2. A is matched against the full position. A > 2*B+1 suppresses the A match, and the output stays off.
- R6: A cause flag is set on a match and holds until 1 is written to its bit in register 3. Writing 0 leaves it unchanged.
- R7: When a match and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: irq_a_o and irq_b_o equal the A and B flags ANDed with their enable bits. The enables reset to 0.
- R9: The invert bit (control bit2) flips the pin, so the off level equals the invert bit.
- R10: With A equal to B, both flags are set at that position, and the output stays off without glitching.
- R11: Only the count enable input chosen by the select field advances the timer.
- R12: After reset, all registers read 0, the output is low and both interrupts are low. Reset is released two clock edges after rst_ni rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| cnt_en_i | input | NSEL | candidate count enables |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 3 | write address |
| wr_data_i | input | CNT_W | write data |
| rd_addr_i | input | 3 | read address |
| rd_data_o | output | CNT_W | read data (combinational) |
| tmr_out_o | output | 1 | timer output pin |
| irq_a_o | output | 1 | compare A interrupt |
| irq_b_o | output | 1 | compare B interrupt |

## Verification
The bench builds the block with the defaults CNT_W=16 and NSEL=4, so all four select codes exist and the whole 16-bit compare range can be written. Short compare values keep every period within tens of cycles. This brings the A=0/B=1 minimum, the A=B case and both out-of-range limits within a few hundred cycles. Random patterns on the unselected enables show that only the chosen enable matters.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 3;
  localparam int NIRQ   = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMPB = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd5;

  localparam int BIT_RUN  = 0;
  localparam int BIT_FINE = 1;
  localparam int BIT_INV  = 2;
  localparam int SEL_LSB  = 4;

  typedef struct packed {
    logic hit_b;
    logic hit_a;
  } pwm_hits_t;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NSEL  = 4,
  localparam int SEL_W = $clog2(NSEL),
  localparam int POS_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fine_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic [NSEL-1:0]  cen_i,
  output pwm_hits_t        hits_o,
  output logic             out_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [2**SEL_W-1:0] cen_pad;
  logic [POS_W-1:0]    pos_q, pos_d, pos_inc, last_pos, a_ext;
  logic                out_q, out_d;
  logic                tick, a_ok, hit_a, hit_b;

  always_comb begin
    cen_pad = '0;
    cen_pad[NSEL-1:0] = cen_i;
  end

  assign tick     = run_i & cen_pad[sel_i];
  assign last_pos = fine_i ? {cmp_b_i, 1'b1} : {1'b0, cmp_b_i};
  assign a_ext    = {1'b0, cmp_a_i};
  assign a_ok     = (a_ext <= last_pos);
  assign hit_b    = tick & (pos_q == last_pos);
  assign hit_a    = tick & a_ok & (pos_q == a_ext);
  assign pos_inc  = fine_i ? pos_q + 1'b1 : {1'b0, pos_q[CNT_W-1:0] + 1'b1};

  always_comb begin
    pos_d = pos_q;
    out_d = out_q;
    if (!run_i) begin
      pos_d = '0;
      out_d = 1'b0;
    end else if (hit_b) begin
      pos_d = '0;
      out_d = 1'b0;
    end else begin
      if (tick)  pos_d = pos_inc;
      if (hit_a) out_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      out_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      out_q <= out_d;
    end
  end

  assign hits_o.hit_a = hit_a;
  assign hits_o.hit_b = hit_b;
  assign out_o        = out_q;
  assign cnt_o        = fine_i ? pos_q[POS_W-1:1] : pos_q[CNT_W-1:0];

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_b |=> (pos_q == '0));
  p_stop_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pos_q == '0) && !out_q);
  p_a_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !a_ok) |=> !$rose(out_q));
  p_equal_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_a && hit_b) |=> !out_q);
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NSEL  = 4,
  localparam int SEL_W = $clog2(NSEL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  pwm_hits_t         hits_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              run_o,
  output logic              fine_o,
  output logic              inv_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CNT_W-1:0]  cmp_a_o,
  output logic [CNT_W-1:0]  cmp_b_o,
  output logic [NIRQ-1:0]   irq_o,
  output logic [CNT_W-1:0]  rd_data_o
);
  logic             run_q, run_d, fine_q, fine_d, inv_q, inv_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] a_q, a_d, b_q, b_d;
  logic [NIRQ-1:0]  ien_q, ien_d, flag_q, flag_d, clr, set;
  logic [CNT_W-1:0] ctrl_rd;

  assign set = {hits_i.hit_b, hits_i.hit_a};

  always_comb begin
    run_d = run_q; fine_d = fine_q; inv_d = inv_q; sel_d = sel_q;
    a_d = a_q; b_d = b_q; ien_d = ien_q; clr = '0;
    if (wr_en_i) begin
      case (wr_addr_i)
        ADR_CTRL: begin
          run_d = wr_data_i[BIT_RUN];
          inv_d = wr_data_i[BIT_INV];
          if (!run_q) begin
            fine_d = wr_data_i[BIT_FINE];
            sel_d  = wr_data_i[SEL_LSB +: SEL_W];
          end
        end
        ADR_CMPA: a_d   = wr_data_i;
        ADR_CMPB: b_d   = wr_data_i;
        ADR_FLAG: clr   = wr_data_i[NIRQ-1:0];
        ADR_IEN:  ien_d = wr_data_i[NIRQ-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; fine_q <= 1'b0; inv_q <= 1'b0; sel_q <= '0;
      a_q <= '0; b_q <= '0; ien_q <= '0;
    end else begin
      run_q <= run_d; fine_q <= fine_d; inv_q <= inv_d; sel_q <= sel_d;
      a_q <= a_d; b_q <= b_d; ien_q <= ien_d;
    end
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_flag
    assign flag_d[i] = (flag_q[i] & ~clr[i]) | set[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= flag_d[i];
    end

    assign irq_o[i] = flag_q[i] & ien_q[i];

    p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr[i]) |=> flag_q[i]);
    p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set[i] |=> flag_q[i]);
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[BIT_RUN]  = run_q;
    ctrl_rd[BIT_FINE] = fine_q;
    ctrl_rd[BIT_INV]  = inv_q;
    ctrl_rd[SEL_LSB +: SEL_W] = sel_q;
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADR_CTRL: rd_data_o = ctrl_rd;
      ADR_CMPA: rd_data_o = a_q;
      ADR_CMPB: rd_data_o = b_q;
      ADR_FLAG: rd_data_o[NIRQ-1:0] = flag_q;
      ADR_IEN:  rd_data_o[NIRQ-1:0] = ien_q;
      ADR_CNT:  rd_data_o = cnt_i;
      default: ;
    endcase
  end

  assign run_o   = run_q;
  assign fine_o  = fine_q;
  assign inv_o   = inv_q;
  assign sel_o   = sel_q;
  assign cmp_a_o = a_q;
  assign cmp_b_o = b_q;

  p_cfg_locked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> ($stable(fine_q) && $stable(sel_q)));
endmodule

// File: rtl/pwm_timer2c.sv
module pwm_timer2c
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NSEL  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSEL-1:0]   cnt_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              tmr_out_o,
  output logic              irq_a_o,
  output logic              irq_b_o
);
  localparam int SEL_W = $clog2(NSEL);

  logic             rst_int_n, run, fine, inv, out_lvl;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] cmp_a, cmp_b, cnt;
  logic [NIRQ-1:0]  irq;
  pwm_hits_t        hits;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_int_n));

  pwm_regs #(.CNT_W(CNT_W), .NSEL(NSEL)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_int_n), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .hits_i(hits), .cnt_i(cnt), .run_o(run), .fine_o(fine), .inv_o(inv),
    .sel_o(sel), .cmp_a_o(cmp_a), .cmp_b_o(cmp_b), .irq_o(irq),
    .rd_data_o(rd_data_o));

  pwm_core #(.CNT_W(CNT_W), .NSEL(NSEL)) u_core (
    .clk_i(clk_i), .rst_ni(rst_int_n), .run_i(run), .fine_i(fine),
    .sel_i(sel), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .cen_i(cnt_en_i),
    .hits_o(hits), .out_o(out_lvl), .cnt_o(cnt));

  assign tmr_out_o = out_lvl ^ inv;
  assign irq_a_o   = irq[0];
  assign irq_b_o   = irq[1];
endmodule

// File: tb/test_pwm_timer2c.sv
module test_pwm_timer2c;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cen = 4'hF;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        tmr_out, irq_a, irq_b;

  int total = 0, bad = 0, cyc = 0;
  bit cen_rand = 1'b0;
  string tag = "R12";

  pwm_timer2c i_pwm_timer2c (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cen), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .tmr_out_o(tmr_out), .irq_a_o(irq_a), .irq_b_o(irq_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_s1, m_s2, m_run, m_fine, m_inv, m_sel, m_a, m_b;
  int m_fa, m_fb, m_ea, m_eb, m_pos, m_out;

  function automatic int exp_rd(int adr);
    case (adr)
      0: return m_run | (m_fine << 1) | (m_inv << 2) | (m_sel << 4);
      1: return m_a;
      2: return m_b;
      3: return m_fa | (m_fb << 1);
      4: return m_ea | (m_eb << 1);
      5: return m_fine ? (m_pos >> 1) : (m_pos & 16'hFFFF);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_run = 0; m_fine = 0; m_inv = 0; m_sel = 0;
      m_a = 0; m_b = 0; m_fa = 0; m_fb = 0; m_ea = 0; m_eb = 0;
      m_pos = 0; m_out = 0;
    end else if (m_s2 == 0) begin
      m_s2 = m_s1; m_s1 = 1;
    end else begin
      int tick, last, ma, mb, clra, clrb;
      tick = m_run && cen[m_sel];
      last = m_fine ? 2 * m_b + 1 : m_b;
      mb = tick && (m_pos == last);
      ma = tick && (m_a <= last) && (m_pos == m_a);
      clra = wr_en && wr_addr == 3 && wr_data[0];
      clrb = wr_en && wr_addr == 3 && wr_data[1];
      if (!m_run) begin m_pos = 0; m_out = 0; end
      else if (mb) begin m_pos = 0; m_out = 0; end
      else begin
        if (tick) m_pos = m_fine ? (m_pos + 1) & 17'h1FFFF : (m_pos + 1) & 16'hFFFF;
        if (ma) m_out = 1;
      end
      m_fa = (m_fa && !clra) || ma;
      m_fb = (m_fb && !clrb) || mb;
      if (wr_en) begin
        case (wr_addr)
          0: begin
            if (!m_run) begin m_fine = wr_data[1]; m_sel = wr_data[5:4]; end
            m_run = wr_data[0]; m_inv = wr_data[2];
          end
          1: m_a = wr_data;
          2: m_b = wr_data;
          4: begin m_ea = wr_data[0]; m_eb = wr_data[1]; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    cyc++;
    check("tmr_out", tmr_out, m_out ^ m_inv);
    check("irq_a", irq_a, m_fa & m_ea);
    check("irq_b", irq_b, m_fb & m_eb);
    check("rd_data", rd_data, exp_rd(rd_addr));
  end

  always @(negedge clk) begin
    rd_addr <= 3'(cyc % 6);
    cen <= cen_rand ? 4'($urandom) : 4'hF;
  end

  task automatic wr(int adr, int dat);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(adr); wr_data = 16'(dat);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tag = "R12"; idle(3); rst_n = 1'b1; idle(5);
    tag = "R8";  wr(4, 3);
    tag = "R3";  wr(1, 2); wr(2, 5); wr(0, 1); idle(40);
    tag = "R1";  wr(0, 1 | 2 | (1 << 4)); idle(10); wr(0, 0); idle(3);
    tag = "R11"; wr(0, 2 << 4); cen_rand = 1'b1; wr(0, 1 | (2 << 4)); idle(60);
    wr(0, 0); cen_rand = 1'b0; wr(0, 0);
    tag = "R10"; wr(1, 3); wr(2, 3); wr(0, 1); idle(20); wr(0, 0);
    tag = "R4";  wr(3, 3); wr(1, 7); wr(2, 4); wr(0, 1); idle(20); wr(0, 0);
    tag = "R5";  wr(3, 3); wr(1, 5); wr(2, 3); wr(0, 2); wr(0, 3); idle(30);
    wr(3, 3); wr(1, 8); idle(30); wr(1, 7); idle(20); wr(0, 0); wr(0, 0);
    tag = "R2";  idle(4); wr(1, 0); wr(2, 1); wr(0, 1); idle(12);
    tag = "R9";  wr(0, 1 | 4); idle(12);
    tag = "R6";  wr(3, 3); idle(2); wr(3, 0); idle(6);
    tag = "R7";  wr(1, 0); wr(2, 0); idle(4);
    for (int i = 0; i < 10; i++) wr(3, 3);
    tag = "R8";  wr(4, 0); idle(10); wr(4, 2); idle(10); wr(0, 0); wr(3, 3); idle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule